// File: doc/BRIEF.md
# Serial-Bus Register File with Time Snapshot Freeze

This block is a two-wire serial bus slave that gives a host access to sixteen byte-wide registers. The lower eight registers hold a user-visible copy of a running time count that lives elsewhere on the chip. The upper eight registers are plain storage for control and alarm settings, and they are exposed to neighbouring logic. The host can write a register pointer and then a burst of data. It can also write the pointer and then read through a repeated START, or read straight from the pointer it left behind last time. The pointer advances by one after each data byte and wraps at the top of the space.

The block decides when the live time count is copied into the user copy. While a transfer is open and the pointer addresses one of the time registers, copying stops, so a burst read of the time bytes sees one consistent instant. Copying starts again at STOP, or as soon as the pointer moves into the upper half. A host write to a time register raises a one-cycle strobe that carries the whole updated eight-byte image to the time chain.

The bus lines are sampled on the system clock through synchronisers. The data line is driven through an active-low output enable that models an open-drain pad.

Top module: `i2c_regfile_slave`

## Requirements
- R1: The slave acknowledges only an address byte whose upper seven bits equal 1101000 (0xD0 writes, 0xD1 reads). For any other address it leaves SDA released, and the master sees a NACK.
- R2: In a write, the first byte after the address loads the register pointer from its low four bits. Each later byte is stored at the pointer. The slave acknowledges the address, the pointer byte and every data byte.
- R3: The pointer advances by one on the acknowledge clock of every data byte, in both reads and writes, and wraps from 0x0F to 0x00.
- R4: After a pointer write, a repeated START with a read address returns the byte at that pointer, followed by consecutive bytes for as long as the master acknowledges.
- R5: A read that is not preceded by a pointer write starts at the pointer value left by the previous transfer.
- R6: A master NACK ends a read. The slave keeps SDA released (sda_oe_n = 1) through any further clocks until the next START or STOP.
- R7: While an addressed transfer is open and the pointer is in 0x00-0x07, the user time copy does not follow time_live_i.
- R8: Copying of time_live_i into the user copy resumes after STOP, and also as soon as the pointer reaches 0x08-0x0F.
- R9: A data write to address 0x00-0x07 raises time_wr_o for exactly one cycle. time_set_o then holds the full image, with byte k in bits [8k+7:8k] and the new byte in place.
- R10: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. The slave changes its SDA drive only while SCL is low.
- R11: After reset, SDA is released, time_wr_o is low, all configuration bytes are zero and the pointer is 0x00.
- R12: cfg_o exposes register 0x08+k in bits [8k+7:8k], for k = 0..7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe_n | output | 1 | Active-low SDA pull-down enable (0 drives the line low) |
| time_live_i | input | 64 | Live time count, byte k in bits [8k+7:8k] |
| time_wr_o | output | 1 | One-cycle strobe: host wrote a time register |
| time_set_o | output | 64 | User time copy; holds the new image while time_wr_o is high |
| cfg_o | output | 64 | Registers 0x08-0x0F, byte k is register 0x08+k |

## Verification
The delicate coincidence is the pointer stepping from 0x07 to 0x08 on an acknowledge clock while the live time value changes. In that cycle freezing ends and copying must begin. The bench reads bytes 0x06 and 0x07 and acknowledges the second. It then swaps in a new live pattern while the pointer rests at 0x08, moves the pointer back to 0x00 under a repeated START, and reads byte 0. The test passes only if bytes 0x06 and 0x07 carry the old pattern and byte 0 carries the new one. A second coincidence is a host write into a frozen time register. The strobe image must then combine the frozen bytes with the written one and must not pick up the live input.

// File: rtl/i2c_rf_pkg.sv
package i2c_rf_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR,
        ST_WR_ACK,
        ST_RD,
        ST_RD_ACK
    } i2c_st_e;

endpackage

// File: rtl/i2c_rf_sync.sv
module i2c_rf_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic sda_o,
    output logic rise_o,
    output logic fall_o,
    output logic start_o,
    output logic stop_o
);

    typedef struct packed {
        logic [STAGES-1:0] scl;
        logic [STAGES-1:0] sda;
        logic              scl_p;
        logic              sda_p;
    } sync_t;

    sync_t q, d;

    assign scl_o = q.scl[STAGES-1];
    assign sda_o = q.sda[STAGES-1];

    always_comb begin
        d       = q;
        d.scl   = (q.scl << 1) | STAGES'(scl_i);
        d.sda   = (q.sda << 1) | STAGES'(sda_i);
        d.scl_p = scl_o;
        d.sda_p = sda_o;
    end

    // Edges and bus conditions come from the synchronised stage and its previous value.
    assign rise_o  =  scl_o & ~q.scl_p;
    assign fall_o  = ~scl_o &  q.scl_p;
    assign start_o =  scl_o &  q.scl_p &  q.sda_p & ~sda_o;
    assign stop_o  =  scl_o &  q.scl_p & ~q.sda_p &  sda_o;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '1;
        else        q <= d;
    end

endmodule

// File: rtl/i2c_rf_store.sv
module i2c_rf_store #(
    parameter int NREG  = 16,
    parameter int NTIME = 8,
    parameter int PW    = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NTIME*8-1:0]    time_live_i,
    input  logic                  xfer_i,
    input  logic [PW-1:0]         ptr_i,
    input  logic                  wr_en_i,
    input  logic [7:0]            wr_data_i,
    output logic [7:0]            rd_data_o,
    output logic                  time_wr_o,
    output logic [NTIME*8-1:0]    time_set_o,
    output logic [(NREG-NTIME)*8-1:0] cfg_o
);

    localparam int NCFG = NREG - NTIME;
    localparam int TW   = $clog2(NTIME);
    localparam int CW   = $clog2(NCFG);
    localparam logic [PW-1:0] LIM = PW'(NTIME);

    typedef struct packed {
        logic [NTIME-1:0][7:0] tm;
        logic [NCFG-1:0][7:0]  cf;
        logic                  stb;
    } store_t;

    store_t q, d;
    logic   in_time;
    logic   freeze;
    logic [PW-1:0] cfg_off;

    assign in_time = (ptr_i < LIM);
    assign freeze  = xfer_i & in_time;
    assign cfg_off = ptr_i - LIM;

    always_comb begin
        d     = q;
        d.stb = 1'b0;
        if (!freeze) d.tm = time_live_i;
        if (wr_en_i) begin
            if (in_time) begin
                d.tm[ptr_i[TW-1:0]] = wr_data_i;
                d.stb               = 1'b1;
            end else begin
                d.cf[cfg_off[CW-1:0]] = wr_data_i;
            end
        end
    end

    assign rd_data_o  = in_time ? q.tm[ptr_i[TW-1:0]] : q.cf[cfg_off[CW-1:0]];
    assign time_wr_o  = q.stb;
    assign time_set_o = q.tm;
    assign cfg_o      = q.cf;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

endmodule

// File: rtl/i2c_regfile_slave.sv
module i2c_regfile_slave
    import i2c_rf_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h68,
    parameter int         NREG        = 16,
    parameter int         NTIME       = 8,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      scl_i,
    input  logic                      sda_i,
    output logic                      sda_oe_n,
    input  logic [NTIME*8-1:0]        time_live_i,
    output logic                      time_wr_o,
    output logic [NTIME*8-1:0]        time_set_o,
    output logic [(NREG-NTIME)*8-1:0] cfg_o
);

    localparam int PW = $clog2(NREG);

    typedef struct packed {
        i2c_st_e        st;
        logic [3:0]     cnt;
        logic [7:0]     sh;
        logic [7:0]     tx;
        logic           rw;
        logic           ptr_ph;
        logic           inc;
        logic           xfer;
        logic           oe_n;
        logic [PW-1:0]  ptr;
    } fsm_t;

    fsm_t q, d;

    logic scl_s, sda_s, rise, fall, start_c, stop_c;
    logic wr_en;
    logic [7:0] rd_data;
    logic xfer_q;
    logic [PW-1:0] ptr_q;

    i2c_rf_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_i   (scl_i),
        .sda_i   (sda_i),
        .scl_o   (scl_s),
        .sda_o   (sda_s),
        .rise_o  (rise),
        .fall_o  (fall),
        .start_o (start_c),
        .stop_o  (stop_c)
    );

    i2c_rf_store #(.NREG(NREG), .NTIME(NTIME), .PW(PW)) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .time_live_i (time_live_i),
        .xfer_i      (q.xfer),
        .ptr_i       (q.ptr),
        .wr_en_i     (wr_en),
        .wr_data_i   (q.sh),
        .rd_data_o   (rd_data),
        .time_wr_o   (time_wr_o),
        .time_set_o  (time_set_o),
        .cfg_o       (cfg_o)
    );

    always_comb begin
        d     = q;
        wr_en = 1'b0;
        if (start_c) begin
            d.st   = ST_ADDR;
            d.cnt  = '0;
            d.oe_n = 1'b1;
        end else if (stop_c) begin
            d.st   = ST_IDLE;
            d.oe_n = 1'b1;
            d.xfer = 1'b0;
        end else begin
            unique case (q.st)
                ST_ADDR: begin
                    if (rise) begin
                        d.sh  = {q.sh[6:0], sda_s};
                        d.cnt = q.cnt + 4'd1;
                    end else if (fall && q.cnt == 4'd8) begin
                        if (q.sh[7:1] == DEV_ADDR) begin
                            d.st   = ST_ADDR_ACK;
                            d.oe_n = 1'b0;
                            d.rw   = q.sh[0];
                            d.xfer = 1'b1;
                        end else begin
                            d.st = ST_IDLE;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (fall) begin
                        d.cnt = '0;
                        if (q.rw) begin
                            d.st   = ST_RD;
                            d.tx   = rd_data;
                            d.oe_n = rd_data[7];
                        end else begin
                            d.st     = ST_WR;
                            d.oe_n   = 1'b1;
                            d.ptr_ph = 1'b1;
                        end
                    end
                end
                ST_WR: begin
                    if (rise) begin
                        d.sh  = {q.sh[6:0], sda_s};
                        d.cnt = q.cnt + 4'd1;
                    end else if (fall && q.cnt == 4'd8) begin
                        d.st   = ST_WR_ACK;
                        d.oe_n = 1'b0;
                        if (q.ptr_ph) begin
                            d.ptr    = q.sh[PW-1:0];
                            d.ptr_ph = 1'b0;
                            d.inc    = 1'b0;
                        end else begin
                            wr_en = 1'b1;
                            d.inc = 1'b1;
                        end
                    end
                end
                ST_WR_ACK: begin
                    if (fall) begin
                        d.st   = ST_WR;
                        d.cnt  = '0;
                        d.oe_n = 1'b1;
                        d.inc  = 1'b0;
                        if (q.inc) d.ptr = q.ptr + 1'b1;
                    end
                end
                ST_RD: begin
                    if (rise) begin
                        d.cnt = q.cnt + 4'd1;
                    end else if (fall) begin
                        if (q.cnt == 4'd8) begin
                            d.st   = ST_RD_ACK;
                            d.oe_n = 1'b1;
                        end else begin
                            d.tx   = {q.tx[6:0], 1'b0};
                            d.oe_n = q.tx[6];
                        end
                    end
                end
                ST_RD_ACK: begin
                    if (rise) begin
                        d.ptr = q.ptr + 1'b1;
                        d.inc = ~sda_s;
                    end else if (fall) begin
                        d.inc = 1'b0;
                        d.cnt = '0;
                        if (q.inc) begin
                            d.st   = ST_RD;
                            d.tx   = rd_data;
                            d.oe_n = rd_data[7];
                        end else begin
                            d.st = ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    assign sda_oe_n = q.oe_n;
    assign xfer_q   = q.xfer;
    assign ptr_q    = q.ptr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_IDLE;
            q.oe_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/i2c_rf_checker.sv
module i2c_rf_checker #(
    parameter int PW    = 4,
    parameter int NTIME = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               scl_i,
    input logic               sda_oe_n,
    input logic               time_wr_o,
    input logic               xfer,
    input logic [PW-1:0]      ptr,
    input logic               wr_en,
    input logic [NTIME*8-1:0] time_live_i,
    input logic [NTIME*8-1:0] time_set_o
);

    localparam logic [PW-1:0] LIM = PW'(NTIME);

    assert_sda_moves_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe_n) |-> !scl_i);

    assert_strobe_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        time_wr_o |=> !time_wr_o);

    assert_copy_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && (ptr < LIM) && !wr_en) |=> $stable(time_set_o));

    assert_copy_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(xfer && (ptr < LIM)) |=> (time_set_o == $past(time_live_i)));

    assert_strobe_in_xfer_R9: assert property (@(posedge clk) disable iff (!rst_n)
        time_wr_o |-> $past(xfer));

endmodule

bind i2c_regfile_slave i2c_rf_checker #(.PW(PW), .NTIME(NTIME)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_i       (scl_i),
    .sda_oe_n    (sda_oe_n),
    .time_wr_o   (time_wr_o),
    .xfer        (xfer_q),
    .ptr         (ptr_q),
    .wr_en       (wr_en),
    .time_live_i (time_live_i),
    .time_set_o  (time_set_o)
);

// File: tb/i2c_regfile_slave_tb.sv
module i2c_regfile_slave_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic [63:0] live = '0;
    logic        sda_oe_n, time_wr_o;
    logic [63:0] time_set_o, cfg_o;
    wire         sda_line = sda_m & sda_oe_n;

    int checks = 0;
    int errors = 0;
    int stb_cnt = 0;
    int oe_low = 0;
    int viol = 0;
    logic [63:0] stb_data = '0;
    logic        oe_prev = 1'b1;

    always #2 clk = ~clk;

    i2c_regfile_slave u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (scl_m),
        .sda_i       (sda_line),
        .sda_oe_n    (sda_oe_n),
        .time_live_i (live),
        .time_wr_o   (time_wr_o),
        .time_set_o  (time_set_o),
        .cfg_o       (cfg_o)
    );

    always @(negedge clk) begin
        if (time_wr_o) begin
            stb_cnt  <= stb_cnt + 1;
            stb_data <= time_set_o;
        end
        if (!sda_oe_n) oe_low <= oe_low + 1;
        if (rst_n && (sda_oe_n != oe_prev) && scl_m) viol <= viol + 1;
        oe_prev <= sda_oe_n;
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wq();
        repeat (10) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b0; wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b1; wq();
    endtask

    task automatic bit_w(input logic b);
        sda_m = b; wq();
        scl_m = 1'b1; wq(); wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic bit_r(output logic b);
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq();
        b = sda_line; wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic wbyte(input logic [7:0] v, output logic nack);
        for (int i = 7; i >= 0; i--) bit_w(v[i]);
        bit_r(nack);
    endtask

    task automatic rbyte(output logic [7:0] v, input logic nack);
        for (int i = 7; i >= 0; i--) bit_r(v[i]);
        bit_w(nack);
    endtask

    task automatic t_reset();
        chk("R11 sda released", 64'(sda_oe_n), 64'd1);
        chk("R11 no strobe", 64'(time_wr_o), 64'd0);
        chk("R11 cfg zero", cfg_o, 64'd0);
    endtask

    task automatic t_wrong_addr();
        logic a;
        oe_low = 0;
        bus_start();
        wbyte(8'hA0, a);
        chk("R1 foreign address NACK", 64'(a), 64'd1);
        chk("R1 SDA untouched", 64'(oe_low), 64'd0);
        bus_stop();
    endtask

    task automatic t_cfg_wrap();
        logic a0, a1, a2, a3, a4;
        logic [63:0] L1 = 64'hA1B2C3D4E5F60718;
        live = L1; wq();
        stb_cnt = 0;
        bus_start();
        wbyte(8'hD0, a0); wbyte(8'h0E, a1);
        wbyte(8'h11, a2); wbyte(8'h22, a3); wbyte(8'h33, a4);
        bus_stop();
        chk("R2 acks", {59'd0, a0, a1, a2, a3, a4}, 64'd0);
        chk("R12 reg 0x0E", 64'(cfg_o[48 +: 8]), 64'h11);
        chk("R12 reg 0x0F", 64'(cfg_o[56 +: 8]), 64'h22);
        chk("R3 wrap strobe count", 64'(stb_cnt), 64'd1);
        chk("R3 wrap lands at 0x00", stb_data, {L1[63:8], 8'h33});
    endtask

    task automatic t_time_write();
        logic a;
        logic [63:0] L2 = 64'h0102030405060708;
        live = L2; wq();
        stb_cnt = 0;
        bus_start();
        wbyte(8'hD0, a); wbyte(8'h02, a); wbyte(8'h45, a); wbyte(8'h67, a);
        bus_stop();
        chk("R9 two strobes", 64'(stb_cnt), 64'd2);
        chk("R9 strobe image", stb_data, {L2[63:32], 8'h67, 8'h45, L2[15:0]});
    endtask

    task automatic t_random_read();
        logic a;
        logic [7:0] v;
        logic [63:0] A = 64'h1122334455667788;
        logic [63:0] B = 64'h99AABBCCDDEEFF00;
        live = A; wq();
        bus_start();
        wbyte(8'hD0, a); wbyte(8'h01, a);
        bus_start();
        wbyte(8'hD1, a);
        chk("R4 read address ack", 64'(a), 64'd0);
        live = B;
        for (int k = 1; k <= 4; k++) begin
            rbyte(v, (k == 4));
            chk("R7 frozen byte during read", 64'(v), 64'(A[8*k +: 8]));
        end
        bus_stop();
        wq();
        bus_start();
        wbyte(8'hD1, a);
        rbyte(v, 1'b1);
        bus_stop();
        chk("R8 copy resumed after STOP, pointer at 5", 64'(v), 64'(B[40 +: 8]));
    endtask

    task automatic t_resume_ptr();
        logic a;
        logic [7:0] v;
        logic [63:0] A2 = 64'h5A5B5C5D5E5F6061;
        logic [63:0] C  = 64'hC0C1C2C3C4C5C6C7;
        live = A2; wq();
        bus_start();
        wbyte(8'hD0, a); wbyte(8'h06, a);
        bus_start();
        wbyte(8'hD1, a);
        rbyte(v, 1'b0);
        chk("R4 sequential byte 6", 64'(v), 64'(A2[48 +: 8]));
        rbyte(v, 1'b0);
        chk("R3 sequential byte 7", 64'(v), 64'(A2[56 +: 8]));
        live = C; wq();
        rbyte(v, 1'b1);
        chk("R3 read crossed into 0x08", 64'(v), 64'(cfg_o[7:0]));
        bus_start();
        wbyte(8'hD0, a); wbyte(8'h00, a);
        bus_start();
        wbyte(8'hD1, a);
        rbyte(v, 1'b1);
        bus_stop();
        chk("R8 copy resumed at pointer 0x08", 64'(v), 64'(C[7:0]));
    endtask

    task automatic t_current_read();
        logic a, b;
        logic [7:0] v;
        bus_start();
        wbyte(8'hD0, a); wbyte(8'h0A, a);
        wbyte(8'h9C, a); wbyte(8'h3E, a); wbyte(8'h71, a);
        bus_stop();
        bus_start();
        wbyte(8'hD0, a); wbyte(8'h0B, a);
        bus_stop();
        bus_start();
        wbyte(8'hD1, a);
        rbyte(v, 1'b0);
        chk("R5 current-address read", 64'(v), 64'h3E);
        rbyte(v, 1'b1);
        chk("R3 read increment", 64'(v), 64'h71);
        oe_low = 0;
        b = 1'b1;
        for (int i = 0; i < 9; i++) begin
            logic s;
            bit_r(s);
            b = b & s;
        end
        chk("R6 line high after NACK", 64'(b), 64'd1);
        chk("R6 no drive after NACK", 64'(oe_low), 64'd0);
        bus_stop();
        chk("R10 drive changed only with SCL low", 64'(viol), 64'd0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_wrong_addr();
        t_cfg_wrap();
        t_time_write();
        t_random_read();
        t_resume_ptr();
        t_current_read();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule